// File: doc/BRIEF.md
# Single-Entry Channel Register

A one-deep mailbox slot between a producer and a consumer. It stores one data word together with a valid flag, which reads back as a count of 0 or 1, and a waiter flag. The producer issues one of four write commands each cycle: conditional write, overwrite, OR-merge or AND-clear. The consumer issues one of four read commands: destructive pop, non-destructive peek, drain, or a wait request. A drain is a pop that clears the valid flag but keeps the data bits. Every command returns a status bit. A consumer that finds the slot empty can register as waiting. The next producer write, or a drain, then clears the waiter flag and raises a one-cycle wake pulse. A separate load port presets the word and the valid flag for initialisation.

The control is a three-state machine. ST_EMPTY has valid clear and no waiter. ST_WAIT has valid clear and the waiter flag set. ST_FULL has valid set. The transitions are:
- EMPTY to WAIT: a wait request.
- EMPTY or WAIT to FULL: a successful conditional write, an overwrite, an OR-merge, or a load.
- WAIT to EMPTY: an AND-clear, or a drain.
- FULL to EMPTY: a pop or a drain.
- Any state to FULL: a load.

A cycle with no command holds the state. When both sides issue a command in the same cycle, the consumer command is applied first. The producer command then acts on the state the consumer command left. All responses are registered and appear in the cycle after the command.

Top module: `chan_slot`

## Requirements
- R1: After reset, cnt and wait_flag are 0. wr_ok, rd_ok, wake and rd_data are 0, and the stored word is 0.
- R2: Conditional write (wr_op=1) on an empty slot stores wr_data, sets cnt and returns wr_ok=1. On a full slot it changes nothing and returns wr_ok=0.
- R3: Overwrite (wr_op=2) replaces the word, sets cnt and clears the waiter. It returns wr_ok=1 only if the slot was empty beforehand.
- R4: OR-merge (wr_op=3) ORs wr_data into the stored word, sets cnt and clears the waiter. It returns wr_ok=1 only if the slot was empty beforehand.
- R5: AND-clear (wr_op=4) clears in the stored word every bit set in wr_data and leaves cnt unchanged. It returns wr_ok=1 if any of those bits had been set.
- R6: Pop (rd_op=1) on a full slot returns the word with rd_ok=1, then zeroes the word and clears cnt. On an empty slot it returns rd_ok=0 and rd_data=0 and changes nothing.
- R7: Peek (rd_op=2) returns the word with rd_ok=1 when full, and rd_ok=0 with rd_data=0 when empty. It never changes the slot.
- R8: Drain (rd_op=3) always returns the stored word on rd_data, with rd_ok equal to the previous cnt. It clears cnt and the waiter and keeps the data bits.
- R9: Wait (rd_op=4) on an empty slot sets wait_flag and returns rd_ok=0. On a full slot it returns the word with rd_ok=1 and changes nothing.
- R10: Any write command, or a drain, that finds the waiter set produces wake=1 for exactly one cycle and clears the waiter. No other cycle produces wake.
- R11: When a read and a write command fall in the same cycle, the read is applied first. The write sees the state the read left behind.
- R12: ld_en=1 stores ld_data, sets cnt and clears the waiter. It produces no wake, and the read and write commands of that cycle are ignored, returning 0 status.
- R13: Responses appear in the cycle after the command. A cycle with neither a command nor a load gives wr_ok=rd_ok=wake=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Direct load strobe |
| ld_data | input | DATA_W | Word to load |
| wr_op | input | 3 | Producer command: 0 none, 1 conditional, 2 overwrite, 3 OR-merge, 4 AND-clear |
| wr_data | input | DATA_W | Producer operand |
| rd_op | input | 3 | Consumer command: 0 none, 1 pop, 2 peek, 3 drain, 4 wait |
| wr_ok | output | 1 | Status of last producer command |
| rd_ok | output | 1 | Status of last consumer command |
| rd_data | output | DATA_W | Word returned by last consumer command |
| wake | output | 1 | One-cycle pulse releasing a waiting consumer |
| cnt | output | 1 | Current valid count (0 or 1) |
| wait_flag | output | 1 | Waiter registered |

## Verification
A consumer command and a producer command can fall in the same cycle. The order between them decides both the status bits and whether wake fires. For example, a wait request on an empty slot followed in that cycle by a write must wake at once, and a pop with a conditional write in the same cycle must let the write succeed. Directed pairs provoke these cases (wait with write, pop with conditional write, drain with OR-merge, peek with AND-clear), and a long stretch of random command pairs follows. Each cycle is judged against a behavioural model that applies the consumer side first.

// File: rtl/chan_slot_pkg.sv
package chan_slot_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FULL  = 2'd2
    } slot_state_e;

    typedef enum logic [2:0] {
        WR_NONE   = 3'd0,
        WR_COND   = 3'd1,
        WR_OVER   = 3'd2,
        WR_OR     = 3'd3,
        WR_ANDCLR = 3'd4
    } wr_op_e;

    typedef enum logic [2:0] {
        RD_NONE  = 3'd0,
        RD_POP   = 3'd1,
        RD_PEEK  = 3'd2,
        RD_DRAIN = 3'd3,
        RD_WAIT  = 3'd4
    } rd_op_e;

endpackage

// File: rtl/chan_slot_cons.sv
module chan_slot_cons
    import chan_slot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  slot_state_e       cur_state,
    input  logic [DATA_W-1:0] cur_data,
    input  rd_op_e            op,
    output slot_state_e       mid_state,
    output logic [DATA_W-1:0] mid_data,
    output logic              ok,
    output logic [DATA_W-1:0] val,
    output logic              drain_wake
);
    localparam logic [DATA_W-1:0] ZERO = '0;

    always_comb begin
        mid_state  = cur_state;
        mid_data   = cur_data;
        ok         = 1'b0;
        val        = ZERO;
        drain_wake = 1'b0;
        unique case (op)
            RD_POP: begin
                if (cur_state == ST_FULL) begin
                    ok        = 1'b1;
                    val       = cur_data;
                    mid_data  = ZERO;
                    mid_state = ST_EMPTY;
                end
            end
            RD_PEEK: begin
                if (cur_state == ST_FULL) begin
                    ok  = 1'b1;
                    val = cur_data;
                end
            end
            RD_DRAIN: begin
                ok         = (cur_state == ST_FULL);
                val        = cur_data;
                drain_wake = (cur_state == ST_WAIT);
                mid_state  = ST_EMPTY;
            end
            RD_WAIT: begin
                if (cur_state == ST_FULL) begin
                    ok  = 1'b1;
                    val = cur_data;
                end else begin
                    mid_state = ST_WAIT;
                end
            end
            default: begin
                mid_state = cur_state;
            end
        endcase
    end

endmodule

// File: rtl/chan_slot_prod.sv
module chan_slot_prod
    import chan_slot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  slot_state_e       mid_state,
    input  logic [DATA_W-1:0] mid_data,
    input  wr_op_e            op,
    input  logic [DATA_W-1:0] operand,
    output slot_state_e       nxt_state,
    output logic [DATA_W-1:0] nxt_data,
    output logic              ok,
    output logic              wake_req
);
    logic was_empty;
    logic was_waiting;

    assign was_empty   = (mid_state != ST_FULL);
    assign was_waiting = (mid_state == ST_WAIT);

    always_comb begin
        nxt_state = mid_state;
        nxt_data  = mid_data;
        ok        = 1'b0;
        wake_req  = 1'b0;
        unique case (op)
            WR_COND: begin
                wake_req = was_waiting;
                if (was_empty) begin
                    nxt_data  = operand;
                    nxt_state = ST_FULL;
                    ok        = 1'b1;
                end
            end
            WR_OVER: begin
                wake_req  = was_waiting;
                ok        = was_empty;
                nxt_data  = operand;
                nxt_state = ST_FULL;
            end
            WR_OR: begin
                wake_req  = was_waiting;
                ok        = was_empty;
                nxt_data  = mid_data | operand;
                nxt_state = ST_FULL;
            end
            WR_ANDCLR: begin
                wake_req = was_waiting;
                ok       = |(mid_data & operand);
                nxt_data = mid_data & ~operand;
                if (was_waiting) begin
                    nxt_state = ST_EMPTY;
                end
            end
            default: begin
                nxt_state = mid_state;
            end
        endcase
    end

endmodule

// File: rtl/chan_slot.sv
module chan_slot
    import chan_slot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [2:0]        wr_op,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_op,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [DATA_W-1:0] rd_data,
    output logic              wake,
    output logic              cnt,
    output logic              wait_flag
);
    localparam logic [DATA_W-1:0] ZERO = '0;

    slot_state_e       state_q, mid_state, nxt_state, step_state;
    logic [DATA_W-1:0] data_q, mid_data, nxt_data, step_data;
    logic              c_ok, p_ok, c_wake, p_wake;
    logic [DATA_W-1:0] c_val;
    wr_op_e            wop;
    rd_op_e            rop;

    assign wop = wr_op_e'(wr_op);
    assign rop = rd_op_e'(rd_op);

    // consumer side acts first
    chan_slot_cons #(.DATA_W(DATA_W)) u_cons (
        .cur_state (state_q),
        .cur_data  (data_q),
        .op        (rop),
        .mid_state (mid_state),
        .mid_data  (mid_data),
        .ok        (c_ok),
        .val       (c_val),
        .drain_wake(c_wake)
    );

    // producer side sees the consumer's result
    chan_slot_prod #(.DATA_W(DATA_W)) u_prod (
        .mid_state(mid_state),
        .mid_data (mid_data),
        .op       (wop),
        .operand  (wr_data),
        .nxt_state(nxt_state),
        .nxt_data (nxt_data),
        .ok       (p_ok),
        .wake_req (p_wake)
    );

    always_comb begin
        if (ld_en) begin
            step_state = ST_FULL;
            step_data  = ld_data;
        end else begin
            step_state = nxt_state;
            step_data  = nxt_data;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            data_q  <= ZERO;
        end else begin
            state_q <= step_state;
            data_q  <= step_data;
        end
    end

    // response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ok   <= 1'b0;
            rd_ok   <= 1'b0;
            rd_data <= ZERO;
            wake    <= 1'b0;
        end else if (ld_en) begin
            wr_ok   <= 1'b0;
            rd_ok   <= 1'b0;
            rd_data <= ZERO;
            wake    <= 1'b0;
        end else begin
            wr_ok   <= p_ok;
            rd_ok   <= c_ok;
            rd_data <= c_val;
            wake    <= c_wake | p_wake;
        end
    end

    assign cnt       = (state_q == ST_FULL);
    assign wait_flag = (state_q == ST_WAIT);

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (!wake && cnt && !wait_flag && !wr_ok && !rd_ok)); // R12
    AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && state_q != ST_WAIT && rd_op != 3'd4) |=> !wake); // R10
    AST_COND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && state_q == ST_FULL && rd_op == 3'd0 && wr_op == 3'd1)
        |=> (!wr_ok && data_q == $past(data_q))); // R2
    AST_PEEK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && rd_op == 3'd2 && wr_op == 3'd0)
        |=> ($stable(data_q) && state_q == $past(state_q))); // R7
    AST_DRAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && rd_op == 3'd3 && wr_op == 3'd0)
        |=> (!cnt && !wait_flag && data_q == $past(data_q))); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && rd_op == 3'd0 && wr_op == 3'd0)
        |=> (!wr_ok && !rd_ok && !wake)); // R13

endmodule

// File: tb/tb_chan_slot.sv
`timescale 1ns/1ps
module tb_chan_slot;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [DW-1:0] ld_data = '0;
    logic [2:0]    wr_op = 3'd0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    rd_op = 3'd0;
    logic          wr_ok, rd_ok, wake, cnt, wait_flag;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [DW-1:0] m_data = '0;
    bit m_valid = 0;
    bit m_wait = 0;

    always #10 clk = ~clk;

    chan_slot #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
        .wr_op(wr_op), .wr_data(wr_data), .rd_op(rd_op),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .rd_data(rd_data),
        .wake(wake), .cnt(cnt), .wait_flag(wait_flag)
    );

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string rtag(input int op);
        case (op)
            1: return "R6";
            2: return "R7";
            3: return "R8";
            4: return "R9";
            default: return "R13";
        endcase
    endfunction

    function automatic string wtag(input int op);
        case (op)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R13";
        endcase
    endfunction

    task automatic step(input bit ld, input logic [DW-1:0] lv, input int rop,
                        input int wop, input logic [DW-1:0] wv);
        bit e_rok = 0, e_wok = 0, e_wake = 0;
        logic [DW-1:0] e_rd = '0;
        string st;
        ld_en = ld; ld_data = lv; rd_op = 3'(rop); wr_op = 3'(wop); wr_data = wv;
        if (ld) begin
            m_data = lv; m_valid = 1; m_wait = 0;
        end else begin
            case (rop)
                1: if (m_valid) begin e_rok = 1; e_rd = m_data; m_data = '0; m_valid = 0; m_wait = 0; end
                2: if (m_valid) begin e_rok = 1; e_rd = m_data; end
                3: begin e_rd = m_data; e_rok = m_valid; if (m_wait) e_wake = 1; m_valid = 0; m_wait = 0; end
                4: if (m_valid) begin e_rok = 1; e_rd = m_data; end else m_wait = 1;
                default: ;
            endcase
            if (wop >= 1 && wop <= 4) begin
                if (m_wait) e_wake = 1;
                m_wait = 0;
                case (wop)
                    1: if (!m_valid) begin m_data = wv; m_valid = 1; e_wok = 1; end
                    2: begin e_wok = !m_valid; m_data = wv; m_valid = 1; end
                    3: begin e_wok = !m_valid; m_data = m_data | wv; m_valid = 1; end
                    default: begin e_wok = ((m_data & wv) != '0); m_data = m_data & ~wv; end
                endcase
            end
        end
        @(posedge clk);
        #1;
        if (ld) st = "R12";
        else if (rop != 0 && wop != 0) st = "R11";
        else if (wop != 0) st = wtag(wop);
        else st = rtag(rop);
        chk(ld ? "R12" : rtag(rop), "rd_ok", DW'(rd_ok), DW'(e_rok));
        chk(ld ? "R12" : rtag(rop), "rd_data", rd_data, e_rd);
        chk(ld ? "R12" : wtag(wop), "wr_ok", DW'(wr_ok), DW'(e_wok));
        chk("R10", "wake", DW'(wake), DW'(e_wake));
        chk(st, "cnt", DW'(cnt), DW'(m_valid));
        chk(st, "wait_flag", DW'(wait_flag), DW'(m_wait));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cnt", DW'(cnt), '0);
        chk("R1", "wait_flag", DW'(wait_flag), '0);
        chk("R1", "rd_data", rd_data, '0);
        chk("R1", "flags", DW'({wr_ok, rd_ok, wake}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        step(0, '0, 2, 0, '0);                          // R7 peek empty
        step(0, '0, 1, 0, '0);                          // R6 pop empty
        step(0, '0, 0, 1, 32'hA5A5_0001);              // R2 cond on empty
        step(0, '0, 0, 1, 32'h1111_1111);              // R2 cond on full
        step(0, '0, 2, 0, '0);                          // R7 peek full
        step(0, '0, 0, 3, 32'h0000_F000);              // R4 OR on full
        step(0, '0, 0, 4, 32'h0000_0F00);              // R5 no overlap
        step(0, '0, 0, 4, 32'h8000_0001);              // R5 overlap
        step(0, '0, 0, 2, 32'hDEAD_BEEF);              // R3 over on full
        step(0, '0, 1, 0, '0);                          // R6 pop full
        step(0, '0, 2, 0, '0);                          // R6 word cleared
        step(0, '0, 4, 0, '0);                          // R9 wait empty
        step(0, '0, 0, 2, 32'h0000_0042);              // R10 wake via overwrite
        step(0, '0, 4, 0, '0);                          // R9 wait full
        step(0, '0, 3, 0, '0);                          // R8 drain
        step(0, '0, 3, 0, '0);                          // R8 drain again, same data
        step(0, '0, 0, 3, 32'h0000_0100);              // R4 OR onto kept bits
        step(0, '0, 1, 1, 32'h0000_0077);              // R11 pop then cond
        step(0, '0, 1, 0, '0);
        step(0, '0, 4, 1, 32'h0000_0099);              // R11 wait+write same cycle, wake
        step(0, '0, 1, 0, '0);
        step(0, '0, 4, 0, '0);
        step(0, '0, 3, 0, '0);                          // R10 drain wakes
        step(0, '0, 4, 0, '0);
        step(0, '0, 0, 4, 32'hFFFF_FFFF);              // R10 AND-clear wakes
        step(0, '0, 4, 0, '0);
        step(1, 32'h1234_5678, 1, 2, 32'h0);            // R12 load ignores cmds
        step(0, '0, 3, 3, 32'h0000_0001);              // R11 drain then OR
        step(0, '0, 2, 4, 32'h1234_0000);              // R11 peek then AND-clear
        step(0, '0, 0, 0, '0);                          // R13 idle
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] v;
            v = ($urandom_range(0, 1) == 0) ? DW'($urandom_range(0, 15)) : DW'($urandom);
            step($urandom_range(0, 15) == 0, DW'($urandom), $urandom_range(0, 4),
                 $urandom_range(0, 4), v);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule